// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits in the bus-interface side of a processor core. It keeps a short first-in first-out queue of upcoming instruction bytes. It fills that queue by itself whenever the bus is free and there is room. Each fetch is a single-byte request on a simple memory port. The port holds a request together with a 16-bit offset until the memory raises ready, and the byte arrives in that same cycle. The decoder takes bytes from the head of the queue through a valid/ready handshake, so no memory latency is seen while bytes are waiting.

The execution side can claim the bus at any time. While it does, no new prefetch is started, but a request that is already on the port runs to completion. A jump or call is signalled with a flush pulse and a new target offset. The flush empties the queue at once, cancels the byte of any fetch still in flight, and restarts fetching at the target. Only the 16-bit fetch offset leaves the block; adding the segment base happens elsewhere.

Top module: `pfq_top`

## Requirements
- R1: The queue holds at most 6 bytes. A fetch is started only while stored bytes plus fetches in flight stay below 6, so with no pops a full queue leaves the request line low.
- R2: Bytes leave the queue in the order in which their fetches completed.
- R3: `q_valid_o` is high in every cycle in which at least one byte is stored and `flush_i` is low. A byte fetched in cycle N is available at the head from cycle N+1.
- R4: While `eu_bus_req_i` is high, no new fetch is started. A request already raised stays high with an unchanged offset until `mem_rdy_i`.
- R5: A flush empties the queue in the cycle after the pulse, and the next fetch uses the flush target offset.
- R6: The byte of a fetch that completes in the flush cycle or after it, but was raised before the flush, is discarded and never reaches the queue.
- R7: The fetch offset advances by one for every byte kept, and wraps from 16'hFFFF to 16'h0000.
- R8: If a flush and a pop arrive in the same cycle, the flush wins. `q_valid_o` is low in that cycle, so no byte is handed over.
- R9: After reset the request line and `q_valid_o` are low and `mem_ofs_o` is 16'h0000.
- R10: While `mem_rdy_i` stays high and room remains, the request stays asserted without a gap, giving one byte per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush_i | input | 1 | Jump/call pulse: discard the queue and refetch from the target |
| flush_ofs_i | input | 16 | Target offset taken with `flush_i` |
| eu_bus_req_i | input | 1 | Execution side wants the bus; blocks new prefetches |
| mem_req_o | output | 1 | Fetch request to memory |
| mem_ofs_o | output | 16 | Offset of the byte being fetched |
| mem_rdy_i | input | 1 | Memory completes the current request this cycle |
| mem_data_i | input | 8 | Fetched byte, valid with `mem_rdy_i` |
| q_valid_o | output | 1 | Head byte is available |
| q_data_o | output | 8 | Head byte |
| q_ready_i | input | 1 | Consumer takes the head byte when valid |

## Verification
The hardest case to reach from the ports is a flush that lands while a fetch is stalled on the memory port. The stale byte must then arrive later and be thrown away, while the refill starts cleanly at the target. The stimulus reaches this case by holding ready low after a request is raised, pulsing the flush, and only then releasing ready with the execution side still holding the bus. A second case, where the flush, a completing fetch and a pop all coincide, is set up the same way with ready and the pop held high. A long run with pseudo-random ready, pop, bus-claim and flush patterns is compared cycle by cycle against a behavioural queue model.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  // State of the single fetch slot on the memory port
  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,  // no request raised
    FS_LIVE  = 2'd1,  // request raised, byte will be kept
    FS_STALE = 2'd2   // request raised before a flush, byte will be dropped
  } fetch_st_e;

  function automatic int occ_bits(input int depth);
    return $clog2(depth + 1);
  endfunction

  function automatic int slot_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/pfq_store.sv
module pfq_store
  import pfq_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int BYTE_W = 8,
  localparam int CW    = occ_bits(DEPTH),
  localparam int IW    = slot_bits(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [BYTE_W-1:0] push_data_i,
  input  logic              pop_ready_i,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_data_o,
  output logic [CW-1:0]     cnt_o,
  output logic [CW-1:0]     cnt_next_o
);

  logic [BYTE_W-1:0] slot_q [DEPTH];
  logic [IW-1:0]     rd_q, rd_n;
  logic [IW-1:0]     wr_q, wr_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic              pop;

  // flush masks the head so a same-cycle pop never completes
  assign out_valid_o = (cnt_q != '0) && !flush_i;
  assign pop         = out_valid_o && pop_ready_i;
  assign out_data_o  = slot_q[rd_q];

  function automatic logic [IW-1:0] step_idx(input logic [IW-1:0] idx);
    return (idx == IW'(DEPTH - 1)) ? '0 : idx + 1'b1;
  endfunction

  always_comb begin
    rd_n  = rd_q;
    wr_n  = wr_q;
    cnt_n = cnt_q;
    if (flush_i) begin
      rd_n  = '0;
      wr_n  = '0;
      cnt_n = '0;
    end else begin
      if (pop)    rd_n = step_idx(rd_q);
      if (push_i) wr_n = step_idx(wr_q);
      cnt_n = cnt_q + CW'(push_i) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      cnt_q <= cnt_n;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_i && (wr_q == IW'(i))) slot_q[i] <= push_data_i;
    end
  end

  assign cnt_o      = cnt_q;
  assign cnt_next_o = cnt_n;

  // R1: occupancy never exceeds the capacity
  p_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R1: a byte is never written into a full queue unless one leaves
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> ((cnt_q != CW'(DEPTH)) || pop));

  // R5: a flush leaves the queue empty on the next cycle
  p_flush_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (cnt_q == '0));

endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch
  import pfq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int OFS_W = 16,
  localparam int CW   = occ_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic [OFS_W-1:0] flush_ofs_i,
  input  logic             eu_req_i,
  input  logic             mem_rdy_i,
  input  logic [CW-1:0]    cnt_i,
  input  logic [CW-1:0]    cnt_next_i,
  output logic             mem_req_o,
  output logic [OFS_W-1:0] mem_ofs_o,
  output logic             push_o
);

  fetch_st_e        st_q, st_n;
  logic [OFS_W-1:0] ptr_q, ptr_n;
  logic [OFS_W-1:0] addr_q, addr_n;
  logic             done;
  logic             start;

  assign done   = (st_q != FS_IDLE) && mem_rdy_i;
  assign push_o = (st_q == FS_LIVE) && mem_rdy_i && !flush_i;
  // a new request may follow a completing one in the same cycle
  assign start  = ((st_q == FS_IDLE) || mem_rdy_i) && !eu_req_i &&
                  (cnt_next_i < CW'(DEPTH));

  always_comb begin
    ptr_n = ptr_q;
    if (flush_i)     ptr_n = flush_ofs_i;
    else if (push_o) ptr_n = ptr_q + 1'b1;
  end

  always_comb begin
    st_n   = st_q;
    addr_n = addr_q;
    if (start) begin
      st_n   = FS_LIVE;
      addr_n = ptr_n;
    end else if (done) begin
      st_n   = FS_IDLE;
    end else if (flush_i && (st_q == FS_LIVE)) begin
      st_n   = FS_STALE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      ptr_q  <= '0;
      addr_q <= '0;
    end else begin
      st_q   <= st_n;
      ptr_q  <= ptr_n;
      addr_q <= addr_n;
    end
  end

  assign mem_req_o = (st_q != FS_IDLE);
  assign mem_ofs_o = addr_q;

  // R4: a raised request is held with a stable offset until ready
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_ofs_o)));

  // R4: an idle port stays idle while the execution side owns the bus
  p_eu_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req_o && eu_req_i) |=> !mem_req_o);

  // R1: stored bytes plus the fetch in flight fit the capacity
  p_occupancy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt_i) + 32'(mem_req_o)) <= DEPTH);

  // R7: every kept byte advances the fetch pointer by exactly one
  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |=> (ptr_q == $past(ptr_q) + 1'b1));

  // R5: a flush loads the target into the fetch pointer
  p_flush_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (ptr_q == $past(flush_ofs_i)));

endmodule

// File: rtl/pfq_top.sv
module pfq_top
  import pfq_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int OFS_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [OFS_W-1:0]  flush_ofs_i,
  input  logic              eu_bus_req_i,
  output logic              mem_req_o,
  output logic [OFS_W-1:0]  mem_ofs_o,
  input  logic              mem_rdy_i,
  input  logic [BYTE_W-1:0] mem_data_i,
  output logic              q_valid_o,
  output logic [BYTE_W-1:0] q_data_o,
  input  logic              q_ready_i
);

  localparam int CW = occ_bits(DEPTH);

  logic [1:0]    rst_sync_q;
  logic          core_rst_n;
  logic          push;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_next;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  pfq_store #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_store (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .flush_i     (flush_i),
    .push_i      (push),
    .push_data_i (mem_data_i),
    .pop_ready_i (q_ready_i),
    .out_valid_o (q_valid_o),
    .out_data_o  (q_data_o),
    .cnt_o       (cnt),
    .cnt_next_o  (cnt_next)
  );

  pfq_fetch #(.DEPTH(DEPTH), .OFS_W(OFS_W)) u_fetch (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .flush_i     (flush_i),
    .flush_ofs_i (flush_ofs_i),
    .eu_req_i    (eu_bus_req_i),
    .mem_rdy_i   (mem_rdy_i),
    .cnt_i       (cnt),
    .cnt_next_i  (cnt_next),
    .mem_req_o   (mem_req_o),
    .mem_ofs_o   (mem_ofs_o),
    .push_o      (push)
  );

endmodule

// File: tb/pfq_top_tb.sv
module pfq_top_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush_i;
  logic [15:0] flush_ofs_i;
  logic        eu_bus_req_i;
  logic        mem_req_o;
  logic [15:0] mem_ofs_o;
  logic        mem_rdy_i;
  logic [7:0]  mem_data_i;
  logic        q_valid_o;
  logic [7:0]  q_data_o;
  logic        q_ready_i;

  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  assign mem_data_i = memf(mem_ofs_o);

  pfq_top u_dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_ofs_i(flush_ofs_i),
    .eu_bus_req_i(eu_bus_req_i), .mem_req_o(mem_req_o), .mem_ofs_o(mem_ofs_o),
    .mem_rdy_i(mem_rdy_i), .mem_data_i(mem_data_i), .q_valid_o(q_valid_o),
    .q_data_o(q_data_o), .q_ready_i(q_ready_i)
  );

  int total = 0;
  int bad   = 0;

  // reference model state
  logic [7:0]  mq[$];
  logic        m_req   = 1'b0;
  logic        m_stale = 1'b0;
  logic [15:0] m_addr  = '0;
  logic [15:0] m_ptr   = '0;

  logic        obs_v, obs_req;
  logic [7:0]  obs_d;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic fl, input logic [15:0] tg, input logic eu,
                      input logic rdy, input logic rd);
    logic exp_v, push, pop, start;
    @(negedge clk);
    flush_i = fl; flush_ofs_i = tg; eu_bus_req_i = eu; mem_rdy_i = rdy; q_ready_i = rd;
    #1;
    exp_v = (mq.size() != 0) && !fl;
    chk(q_valid_o === exp_v, "R3 R8 head valid", q_valid_o, exp_v);
    if (exp_v) chk(q_data_o === mq[0], "R2 head byte", q_data_o, mq[0]);
    chk(mem_req_o === m_req, "R1 R4 request", mem_req_o, m_req);
    chk(mem_ofs_o === m_addr, "R7 offset", mem_ofs_o, m_addr);
    obs_v = q_valid_o; obs_d = q_data_o; obs_req = mem_req_o;
    // model next state
    push = m_req && !m_stale && rdy && !fl;
    pop  = exp_v && rd;
    if (fl) mq.delete();
    else begin
      if (pop)  void'(mq.pop_front());
      if (push) mq.push_back(memf(m_addr));
    end
    if (fl) m_ptr = tg;
    else if (push) m_ptr = m_ptr + 16'd1;
    start = (!m_req || rdy) && !eu && (mq.size() < 6);
    if (start) begin
      m_req = 1'b1; m_stale = 1'b0; m_addr = m_ptr;
    end else if (m_req && rdy) begin
      m_req = 1'b0; m_stale = 1'b0;
    end else if (fl && m_req) begin
      m_stale = 1'b1;
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", total, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] got [3];
    int n;
    rst_n = 1'b0; flush_i = 1'b0; flush_ofs_i = '0; eu_bus_req_i = 1'b1;
    mem_rdy_i = 1'b0; q_ready_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk(mem_req_o === 1'b0, "R9 reset request", mem_req_o, 0);
    chk(q_valid_o === 1'b0, "R9 reset valid", q_valid_o, 0);
    chk(mem_ofs_o === 16'h0, "R9 reset offset", mem_ofs_o, 0);
    rst_n = 1'b1;
    repeat (4) step(0, 0, 1, 0, 0);

    // R1 R10: fill with ready held high, no pops
    repeat (40) step(0, 0, 0, 1, 0);
    chk(obs_req === 1'b0, "R1 full queue request low", obs_req, 0);
    chk(obs_v === 1'b1, "R1 full queue valid", obs_v, 1);
    // R2: drain in order
    repeat (8) step(0, 0, 1, 0, 1);

    // R2 R3: random ready and pop
    repeat (80) step(0, 0, 0, lfsr[0], lfsr[3]);
    // R4: random bus claims
    repeat (120) step(0, 0, lfsr[5] | lfsr[7], lfsr[1], lfsr[2]);

    // R5 R6: flush while a fetch stalls on the port
    step(1, 16'h0100, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(1, 16'h1234, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 1, 0);  // stale byte returns, bus claimed
    step(0, 0, 1, 0, 0);
    chk(obs_v === 1'b0, "R6 stale byte dropped", obs_v, 0);
    repeat (4) step(0, 0, 0, 1, 0);
    chk(obs_d === memf(16'h1234), "R5 first byte at target", obs_d, memf(16'h1234));

    // R8: flush, completing fetch and pop coincide
    repeat (3) step(0, 0, 0, 1, 0);
    step(1, 16'h2000, 0, 1, 1);
    chk(obs_v === 1'b0, "R8 flush masks pop", obs_v, 0);
    step(0, 0, 0, 1, 0);
    chk(obs_v === 1'b0, "R8 queue empty after flush", obs_v, 0);
    repeat (8) step(0, 0, 0, 1, 0);

    // R7 R10: wrap of the offset and back-to-back fetches
    step(1, 16'hFFFE, 0, 1, 0);
    n = 0;
    for (int k = 0; k < 6; k++) begin
      step(0, 0, 0, 1, 0);
      if (obs_req) n++;
    end
    chk(n == 6, "R10 gapless requests", n, 6);
    step(0, 0, 0, 1, 0);
    chk(obs_req === 1'b0, "R1 request stops at capacity", obs_req, 0);
    for (int k = 0; k < 3; k++) begin
      step(0, 0, 1, 0, 1);
      got[k] = obs_d;
    end
    chk(got[0] === memf(16'hFFFE), "R7 byte at FFFE", got[0], memf(16'hFFFE));
    chk(got[1] === memf(16'hFFFF), "R7 byte at FFFF", got[1], memf(16'hFFFF));
    chk(got[2] === memf(16'h0000), "R7 byte after wrap", got[2], memf(16'h0000));

    // mixed long run with occasional flushes
    for (int k = 0; k < 3000; k++) begin
      step(lfsr[15:11] == 5'h1F, lfsr ^ 16'h5A5A, lfsr[4] & lfsr[8],
           lfsr[6] | lfsr[9], lfsr[10] | lfsr[2]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule